// File: doc/BRIEF.md
# Non-Volatile Memory Command Controller with Debug Access Gate

This block connects a byte-addressed debug and programming bus to a small on-chip non-volatile store, which is modelled here as a register array. The bus sees a handful of control registers in the low half of the address space and the store itself in the upper half. No access to the store is possible until the host opens a gate. To do that it writes a signature byte to a reset register and then shifts a 64-bit key in one byte at a time. The host then polls an enable bit until it reads 1.

Once the gate is open, the host loads a 7-bit command code. Each command has one trigger. Action commands (chip erase, checksum) run when an execute bit is written. The read command runs on a bus load from the store window. The buffer-load and page-write commands run on a bus store to the store window. Erase and page write hold a busy flag for a fixed number of cycles, and every store read is refused during that time. When both lock bits are set, only erase and checksum are accepted. Every refused operation returns 0x00 and sets a sticky error bit.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: The enable bit (STATUS bit 0) rises only in this case: byte 0x59 is written to RESET (offset 0x0), then exactly eight bytes are written to KEY (offset 0x1), most significant byte first, and together they equal the KEY parameter. A key with any wrong byte, or a key sent without the signature, leaves the bit at 0. Any write to RESET clears the bit.
- R2: Register offsets are STATUS 0x2 ({5'b0, err, busy, enable}), CMD 0x3, CTRL 0x4 (bit 0 execute), LOCK 0x5 (bit 0 read lock, bit 1 write lock) and SUM 0x6. CMD is 7 bits wide and reads back with bit 7 at 0. The command codes are 0x00 no-op, 0x40 chip erase, 0x43 read, 0x23 buffer load, 0x25 page write and 0x78 checksum.
- R3: Writing 1 to CTRL bit 0 sets the execute bit. One cycle later the loaded action command runs and the bit clears. The checksum command loads SUM with the XOR of all store bytes.
- R4: With command 0x43 loaded, a load at address 0x8000+n returns store byte n on the read data bus one cycle later, with the read-valid pulse high.
- R5: A store load while any other command is loaded returns 0x00 and sets the error bit.
- R6: With command 0x23, a store to 0x8000+a writes the byte into page-buffer slot a[3:0]. With command 0x25, a store to 0x8000+a copies the buffer into page a[7:4] and holds busy for 16 cycles.
- R7: Chip erase sets every store byte and every buffer slot to 0xFF, clears both lock bits and holds busy for 64 cycles.
- R8: While busy is high, every store load returns 0x00 and sets the error bit.
- R9: When both lock bits are set, every command other than erase and checksum is refused with the error bit set. Lock bits can only be set by writes; only erase clears them.
- R10: CMD writes while busy is high are ignored.
- R11: The error bit is sticky. Writing 1 to STATUS bit 2 clears it.
- R12: Before the gate is open, a store load returns 0x00 and sets the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address; bit 15 selects the store window |
| bus_wr | input | 1 | Store strobe |
| bus_rd | input | 1 | Load strobe |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Load data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a load |
| enabled | output | 1 | Access gate open |
| busy | output | 1 | Erase or page write in progress |
| err | output | 1 | Sticky error bit |

## Verification
The unlock gate is tried with three inputs: a key without the signature, a signature followed by a wrong key, and the full correct sequence. This separates a missing signature check from a missing key compare. Store loads are issued under the read command, under a no-op, while busy, under both lock bits and before the gate opens. Each of these conditions alone has to produce 0x00 and the error bit, while the read command produces a distinct pattern. Page writes and erases are timed cycle by cycle against 16 and 64 cycles. A one-byte page write after an erase shows whether the old buffer contents survived.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam logic [7:0] UNLOCK_SIG = 8'h59;

    localparam logic [6:0] CMD_NOP   = 7'h00;
    localparam logic [6:0] CMD_ERASE = 7'h40;
    localparam logic [6:0] CMD_READ  = 7'h43;
    localparam logic [6:0] CMD_BUFLD = 7'h23;
    localparam logic [6:0] CMD_PGWR  = 7'h25;
    localparam logic [6:0] CMD_SUM   = 7'h78;

    typedef enum logic [2:0] {
        REG_RST  = 3'd0,
        REG_KEY  = 3'd1,
        REG_STAT = 3'd2,
        REG_CMD  = 3'd3,
        REG_CTRL = 3'd4,
        REG_LOCK = 3'd5,
        REG_SUM  = 3'd6,
        REG_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic err;
        logic busy;
        logic en;
    } nvm_status_t;

    typedef struct packed {
        logic rd_lock;
        logic wr_lock;
    } nvm_lock_t;

    // Lock filter: with both locks set only erase and checksum pass.
    function automatic logic nvm_cmd_permitted(input logic [6:0] cmd, input nvm_lock_t lk);
        return !(lk.rd_lock && lk.wr_lock) || (cmd == CMD_ERASE) || (cmd == CMD_SUM);
    endfunction

endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
    parameter logic [63:0] KEY = 64'h1289_AB45_CDD8_88FF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sig_we,
    input  logic [7:0] sig_data,
    input  logic       key_we,
    input  logic [7:0] key_data,
    output logic       enabled
);
    import nvm_pkg::*;

    localparam int KEY_BYTES = 8;
    localparam int CNT_W     = $clog2(KEY_BYTES);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [55:0]      sr_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            sr_q    <= '0;
            en_q    <= 1'b0;
        end else if (sig_we) begin
            en_q    <= 1'b0;
            armed_q <= (sig_data == UNLOCK_SIG);
            cnt_q   <= '0;
        end else if (key_we && armed_q) begin
            sr_q  <= {sr_q[47:0], key_data};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(KEY_BYTES - 1)) begin
                armed_q <= 1'b0;
                en_q    <= ({sr_q, key_data} == KEY);
            end
        end
    end

    assign enabled = en_q;

endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          erase,
    input  logic                                          buf_we,
    input  logic [$clog2(PAGE_BYTES)-1:0]                 buf_idx,
    input  logic [7:0]                                    buf_data,
    input  logic                                          pg_we,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] pg_sel,
    input  logic [$clog2(MEM_BYTES)-1:0]                  rd_idx,
    output logic [7:0]                                    rd_data,
    output logic [7:0]                                    checksum
);
    localparam int MEM_W = $clog2(MEM_BYTES);
    localparam int PG_W  = $clog2(PAGE_BYTES);

    logic [7:0] mem_q  [MEM_BYTES];
    logic [7:0] pbuf_q [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst || erase) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
            for (int j = 0; j < PAGE_BYTES; j++) pbuf_q[j] <= 8'hFF;
        end else begin
            if (buf_we) pbuf_q[buf_idx] <= buf_data;
            if (pg_we) begin
                for (int j = 0; j < PAGE_BYTES; j++)
                    mem_q[{pg_sel, PG_W'(j)}] <= pbuf_q[j];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

    always_comb begin
        checksum = 8'h00;
        for (int i = 0; i < MEM_BYTES; i++) checksum = checksum ^ mem_q[i];
    end

    logic unused_w;
    assign unused_w = ^MEM_W;

endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl #(
    parameter int          ADDR_W     = 16,
    parameter int          MEM_BYTES  = 256,
    parameter int          PAGE_BYTES = 16,
    parameter int          ERASE_CYC  = 64,
    parameter int          PAGE_CYC   = 16,
    parameter logic [63:0] KEY        = 64'h1289_AB45_CDD8_88FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    output logic              enabled,
    output logic              busy,
    output logic              err
);
    import nvm_pkg::*;

    localparam int MEM_W   = $clog2(MEM_BYTES);
    localparam int PG_W    = $clog2(PAGE_BYTES);
    localparam int SEL_W   = MEM_W - PG_W;
    localparam int MAX_CYC = (ERASE_CYC > PAGE_CYC) ? ERASE_CYC : PAGE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    // Address decode
    logic     mem_space, mem_hit, reg_hit;
    reg_sel_e reg_sel;

    assign mem_space = bus_addr[ADDR_W-1];
    assign mem_hit   = mem_space && (bus_addr[ADDR_W-2:MEM_W] == '0);
    assign reg_hit   = !mem_space && (bus_addr[ADDR_W-2:3] == '0);
    assign reg_sel   = reg_hit ? reg_sel_e'(bus_addr[2:0]) : REG_NONE;

    logic key_wr, sig_wr, cmd_wr, ctrl_req, ctrl_set, lock_wr, err_clr;
    assign sig_wr   = bus_wr && (reg_sel == REG_RST);
    assign key_wr   = bus_wr && (reg_sel == REG_KEY);
    assign cmd_wr   = bus_wr && (reg_sel == REG_CMD);
    assign lock_wr  = bus_wr && (reg_sel == REG_LOCK);
    assign err_clr  = bus_wr && (reg_sel == REG_STAT) && bus_wdata[2];
    assign ctrl_req = bus_wr && (reg_sel == REG_CTRL) && bus_wdata[0];
    assign ctrl_set = ctrl_req && !busy;

    // State
    logic [6:0] cmd_q;
    logic       exec_q;
    nvm_lock_t  lock_q;
    logic       err_q;
    logic [7:0] sum_q;
    logic [7:0] rdata_q;
    logic       rvalid_q;

    logic       erase_go, sum_go, buf_we, pg_we, err_set, mem_rd_ok, permitted;
    logic [7:0] store_rd, store_sum, reg_rd;

    assign permitted = nvm_cmd_permitted(cmd_q, lock_q);

    nvm_unlock #(.KEY(KEY)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .sig_we   (sig_wr),
        .sig_data (bus_wdata),
        .key_we   (key_wr),
        .key_data (bus_wdata),
        .enabled  (enabled)
    );

    nvm_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (erase_go || pg_we),
        .len   (erase_go ? CNT_W'(ERASE_CYC) : CNT_W'(PAGE_CYC)),
        .busy  (busy)
    );

    nvm_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .erase    (erase_go),
        .buf_we   (buf_we),
        .buf_idx  (bus_addr[PG_W-1:0]),
        .buf_data (bus_wdata),
        .pg_we    (pg_we),
        .pg_sel   (bus_addr[MEM_W-1:PG_W]),
        .rd_idx   (bus_addr[MEM_W-1:0]),
        .rd_data  (store_rd),
        .checksum (store_sum)
    );

    // Trigger decode: execute bit, bus store, bus load
    always_comb begin
        erase_go  = 1'b0;
        sum_go    = 1'b0;
        buf_we    = 1'b0;
        pg_we     = 1'b0;
        err_set   = 1'b0;
        mem_rd_ok = 1'b0;

        if (exec_q) begin
            if (!enabled || busy)            err_set  = 1'b1;
            else if (cmd_q == CMD_NOP)       err_set  = 1'b0;
            else if (!permitted)             err_set  = 1'b1;
            else if (cmd_q == CMD_ERASE)     erase_go = 1'b1;
            else if (cmd_q == CMD_SUM)       sum_go   = 1'b1;
            else                             err_set  = 1'b1;
        end

        if (bus_wr && mem_space) begin
            if (!mem_hit || !enabled || busy || erase_go || !permitted) err_set = 1'b1;
            else if (cmd_q == CMD_BUFLD)     buf_we  = 1'b1;
            else if (cmd_q == CMD_PGWR)      pg_we   = 1'b1;
            else                             err_set = 1'b1;
        end

        if (bus_rd && mem_space) begin
            if (mem_hit && enabled && !busy && (cmd_q == CMD_READ) && permitted)
                mem_rd_ok = 1'b1;
            else
                err_set = 1'b1;
        end

        if (ctrl_req && busy) err_set = 1'b1;
    end

    // Register read mux
    always_comb begin
        nvm_status_t st;
        st = '{err: err_q, busy: busy, en: enabled};
        unique case (reg_sel)
            REG_STAT: reg_rd = {5'b0, st};
            REG_CMD:  reg_rd = {1'b0, cmd_q};
            REG_CTRL: reg_rd = {7'b0, exec_q};
            REG_LOCK: reg_rd = {6'b0, lock_q.wr_lock, lock_q.rd_lock};
            REG_SUM:  reg_rd = sum_q;
            default:  reg_rd = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_NOP;
            exec_q   <= 1'b0;
            lock_q   <= '0;
            err_q    <= 1'b0;
            sum_q    <= 8'h00;
            rdata_q  <= 8'h00;
            rvalid_q <= 1'b0;
        end else begin
            exec_q <= ctrl_set;
            if (cmd_wr && !busy) cmd_q <= bus_wdata[6:0];
            if (erase_go) begin
                lock_q <= '0;
            end else if (lock_wr) begin
                lock_q.rd_lock <= lock_q.rd_lock | bus_wdata[0];
                lock_q.wr_lock <= lock_q.wr_lock | bus_wdata[1];
            end
            if (err_set)      err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
            if (sum_go) sum_q <= store_sum;
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= mem_space ? (mem_rd_ok ? store_rd : 8'h00) : reg_rd;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign err        = err_q;

endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_rd,
    input logic       mem_space,
    input logic       busy,
    input logic       enabled,
    input logic [7:0] bus_rdata,
    input logic       err,
    input logic       err_clr,
    input logic       exec_q,
    input logic       ctrl_set,
    input logic [6:0] cmd_q,
    input logic       erase_go,
    input logic [1:0] lock_bits,
    input logic       key_wr
);
    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && mem_space && busy) |=> (bus_rdata == 8'h00 && err));

    // R12
    gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && mem_space && !enabled) |=> (bus_rdata == 8'h00 && err));

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q));

    // R3
    exec_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_q && !ctrl_set) |=> !exec_q);

    // R7
    erase_effect_chk: assert property (@(posedge clk) disable iff (rst)
        erase_go |=> (busy && lock_bits == 2'b00));

    // R1
    gate_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(enabled) |-> $past(key_wr));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !err_clr) |=> err);
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .mem_space (mem_space),
    .busy      (busy),
    .enabled   (enabled),
    .bus_rdata (bus_rdata),
    .err       (err),
    .err_clr   (err_clr),
    .exec_q    (exec_q),
    .ctrl_set  (ctrl_set),
    .cmd_q     (cmd_q),
    .erase_go  (erase_go),
    .lock_bits ({lock_q.wr_lock, lock_q.rd_lock}),
    .key_wr    (key_wr)
);

// File: tb/nvm_cmd_ctrl_bench.sv
module nvm_cmd_ctrl_bench;

    localparam logic [63:0] KEYV = 64'h1289_AB45_CDD8_88FF;
    localparam logic [15:0] A_RST = 16'h0000, A_KEY = 16'h0001, A_STAT = 16'h0002,
                            A_CMD = 16'h0003, A_CTRL = 16'h0004, A_LOCK = 16'h0005,
                            A_SUM = 16'h0006, A_MEM = 16'h8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid, enabled, busy, err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nvm_cmd_ctrl u_nvm_cmd_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .enabled(enabled), .busy(busy), .err(err)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'h5A ^ 8'(i * 19);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Tasks start and end on a falling edge.
    task automatic bwrite(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_read(input logic [15:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        bread(a, d);
        check(d == exp, req, d, exp);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int n;
        count_busy(n);
    endtask

    task automatic clear_err();
        bwrite(A_STAT, 8'h04);
    endtask

    task automatic t_reset();
        expect_read(A_STAT, 8'h00, "R1 reset status");
        expect_read(A_CMD, 8'h00, "R2 reset cmd");
    endtask

    task automatic t_gate_closed();
        bwrite(A_CMD, 8'h43);
        expect_read(A_MEM + 16'h10, 8'h00, "R12 load before unlock");
        check(err == 1'b1, "R12 err set", err, 1);
        clear_err();
        check(err == 1'b0, "R11 err cleared by w1c", err, 0);
    endtask

    task automatic send_key(input logic [63:0] k);
        for (int i = 7; i >= 0; i--) bwrite(A_KEY, k[i*8 +: 8]);
    endtask

    task automatic t_unlock();
        send_key(KEYV);
        expect_read(A_STAT, 8'h00, "R1 key without signature");
        bwrite(A_RST, 8'h59);
        send_key(KEYV ^ 64'h0000_0000_0100_0000);
        expect_read(A_STAT, 8'h00, "R1 wrong key");
        bwrite(A_RST, 8'h59);
        send_key(KEYV);
        expect_read(A_STAT, 8'h01, "R1 correct unlock");
    endtask

    task automatic t_cmd_width();
        bwrite(A_CMD, 8'hFF);
        expect_read(A_CMD, 8'h7F, "R2 cmd 7 bits");
    endtask

    task automatic t_page();
        int n;
        bwrite(A_CMD, 8'h23);
        for (int i = 0; i < 16; i++) bwrite(A_MEM + 16'h30 + 16'(i), pat(i));
        bwrite(A_CMD, 8'h25);
        bwrite(A_MEM + 16'h37, 8'h00);
        count_busy(n);
        check(n == 16, "R6 page write busy cycles", n, 16);
        bwrite(A_CMD, 8'h43);
        for (int i = 0; i < 16; i++) expect_read(A_MEM + 16'h30 + 16'(i), pat(i), "R4 read page data");
        check(bus_rvalid == 1'b1, "R4 rvalid", bus_rvalid, 1);
        expect_read(A_MEM + 16'h40, 8'hFF, "R4 untouched page");
        check(err == 1'b0, "R6 no error on valid ops", err, 0);
    endtask

    task automatic t_wrong_cmd();
        bwrite(A_CMD, 8'h00);
        expect_read(A_MEM + 16'h30, 8'h00, "R5 load under nop");
        check(err == 1'b1, "R5 err set", err, 1);
        clear_err();
    endtask

    task automatic t_checksum();
        logic [7:0] exp = 8'h00;
        for (int i = 0; i < 16; i++) exp ^= pat(i);
        bwrite(A_CMD, 8'h78);
        bwrite(A_CTRL, 8'h01);
        expect_read(A_CTRL, 8'h01, "R3 execute bit visible");
        expect_read(A_CTRL, 8'h00, "R3 execute bit self-clears");
        expect_read(A_SUM, exp, "R3 checksum");
    endtask

    task automatic t_lock();
        logic [7:0] d;
        bwrite(A_LOCK, 8'h03);
        expect_read(A_LOCK, 8'h03, "R9 lock bits set");
        bwrite(A_CMD, 8'h43);
        expect_read(A_MEM + 16'h30, 8'h00, "R9 read refused under lock");
        check(err == 1'b1, "R9 err on locked read", err, 1);
        clear_err();
        bwrite(A_CMD, 8'h23);
        bwrite(A_MEM + 16'h30, 8'h11);
        check(err == 1'b1, "R9 err on locked store", err, 1);
        clear_err();
        bwrite(A_CMD, 8'h78);
        bwrite(A_CTRL, 8'h01);
        bread(A_STAT, d);
        check(err == 1'b0, "R9 checksum allowed under lock", err, 0);
    endtask

    task automatic t_erase_busy();
        bwrite(A_CMD, 8'h40);
        bwrite(A_CTRL, 8'h01);
        @(negedge clk);
        check(busy == 1'b1, "R7 busy after erase", busy, 1);
        bwrite(A_CMD, 8'h43);
        expect_read(A_CMD, 8'h40, "R10 cmd write ignored while busy");
        expect_read(A_MEM + 16'h30, 8'h00, "R8 load blocked while busy");
        check(err == 1'b1, "R8 err while busy", err, 1);
        wait_idle();
        clear_err();
        expect_read(A_LOCK, 8'h00, "R7 locks cleared");
        bwrite(A_CMD, 8'h43);
        expect_read(A_MEM + 16'h30, 8'hFF, "R7 store erased");
    endtask

    task automatic t_erase_time();
        int n;
        bwrite(A_CMD, 8'h23);
        bwrite(A_MEM + 16'h50, 8'h12);
        bwrite(A_CMD, 8'h40);
        bwrite(A_CTRL, 8'h01);
        @(negedge clk);
        count_busy(n);
        check(n == 64, "R7 erase busy cycles", n, 64);
        bwrite(A_CMD, 8'h23);
        bwrite(A_MEM + 16'h50, 8'h12);
        bwrite(A_CMD, 8'h25);
        bwrite(A_MEM + 16'h50, 8'h00);
        wait_idle();
        bwrite(A_CMD, 8'h43);
        expect_read(A_MEM + 16'h50, 8'h12, "R6 buffer slot 0 written");
        expect_read(A_MEM + 16'h51, 8'hFF, "R7 buffer cleared by erase");
        expect_read(A_MEM + 16'h3F, 8'hFF, "R7 old page gone");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gate_closed();
        t_unlock();
        t_cmd_width();
        t_page();
        t_wrong_cmd();
        t_checksum();
        t_lock();
        t_erase_busy();
        t_erase_time();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule